// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, from the six destination address bytes at the head of each frame, whether the frame is kept or dropped. The receive logic pulses `frame_start` at the start of a frame. It then presents the destination bytes one per qualified cycle on `byte_data` with `byte_valid`, in wire order with byte 0 first. Idle cycles may be left between bytes.

The filter builds the address as the bytes arrive. It also runs a CRC-32 over the same bytes. One clock after the sixth byte it raises `verdict_valid` for one cycle, with `verdict_accept` giving the decision. The decision draws on four inputs: the station address, a 64-bit multicast hash table held in two 32-bit words, and three mode bits. The mode bits select promiscuous operation, rejection of broadcast frames, and hash matching for unicast addresses.

Top module: `rx_addr_filter`

## Requirements
- R1: With promiscuous mode off, a unicast frame (bit 0 of byte 0 clear) whose address equals the station address is accepted, and a difference in any one byte rejects it when unicast hash mode is off. Station byte 0 is `stn_upper[15:8]` and byte 1 is `stn_upper[7:0]`. Bytes 2, 3, 4 and 5 are `stn_lower[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R2: The hash index is bits 31:26 of a CRC computed over the six address bytes. The CRC uses polynomial 0x04C11DB7 and an all-ones start value, takes each byte least significant bit first, and is not inverted at the end. Index bit 5 selects `hash_tbl1` when 1 and `hash_tbl0` when 0, and index bits 4:0 pick the bit within that word. A non-broadcast multicast frame (bit 0 of byte 0 set) is accepted exactly when that bit is 1.
- R3: With `mode_promisc` set, every frame is accepted, including a broadcast frame while `mode_bcast_reject` is set.
- R4: A frame addressed to all ones is accepted when `mode_bcast_reject` is 0 and rejected when it is 1, whatever the hash table holds.
- R5: With both hash words all ones, every multicast address is accepted.
- R6: With `mode_ucast_hash` set, a unicast frame that does not match the station address is accepted when its hash bit is 1 and rejected when it is 0. With the mode clear, the hash bit has no effect on unicast frames.
- R7: `verdict_valid` is 1 for exactly one cycle, in the cycle after the sixth address byte is taken, and is 0 at all other times. After reset `verdict_valid` and `verdict_accept` are 0.
- R8: A `frame_start` pulse restarts the CRC and the byte count. A frame cut short by a new `frame_start` produces no verdict, and the new frame is judged on its own bytes only. A byte offered in the same cycle as `frame_start` is not taken.
- R9: Bytes after the sixth are ignored until the next `frame_start`, and they produce no further verdict.
- R10: Idle cycles between address bytes do not change the decision. The verdict still comes one cycle after the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that marks a new frame |
| byte_valid | input | 1 | `byte_data` holds an address byte this cycle |
| byte_data | input | 8 | Destination address byte, byte 0 first |
| stn_upper | input | 16 | Station address bytes 0 (bits 15:8) and 1 (bits 7:0) |
| stn_lower | input | 32 | Station address bytes 2 to 5, byte 2 in bits 31:24 |
| hash_tbl0 | input | 32 | Hash table word used when index bit 5 is 0 |
| hash_tbl1 | input | 32 | Hash table word used when index bit 5 is 1 |
| mode_promisc | input | 1 | Accept every frame |
| mode_bcast_reject | input | 1 | Reject frames addressed to all ones |
| mode_ucast_hash | input | 1 | Also accept unicast frames by hash bit |
| verdict_valid | output | 1 | One-cycle strobe: the decision is present |
| verdict_accept | output | 1 | Decision, valid while `verdict_valid` is 1 |

## Verification
The only result the block produces is the verdict, and it is due exactly one clock after the edge that takes the sixth byte. The bench drives inputs on falling edges. It looks for the strobe at the first falling edge after the sixth byte, and checks again one falling edge later to confirm the strobe has dropped. At every falling edge before the sixth byte it checks that no strobe appears, and that holds also with idle gaps, after an early restart, and while surplus bytes are fed in. Hash indices for the expected values come from a reference CRC written in the bench.

// File: rtl/addr_filt_pkg.sv
// Package: shared constants and types for the receive destination filter.
// Assumes byte 0 of an address occupies the most significant byte of a
// 48-bit vector, so the station address is simply {upper, lower}.
package addr_filt_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam int HASH_WORD_W = 32;
    localparam int HASH_IDX_W  = $clog2(2 * HASH_WORD_W);

    typedef logic [ADDR_W-1:0] mac_addr_t;
    typedef logic [HASH_IDX_W-1:0] hash_idx_t;
endpackage

// File: rtl/addr_crc_byte.sv
// Module: byte-wide CRC engine over the destination address.
// Processes one byte per enabled cycle, least significant bit first, with
// no final inversion. Exposes the hash index the register would hold after
// the byte in flight, so that the decision can be made in the same cycle.
// Assumes clear has priority over en.
module addr_crc_byte
    import addr_filt_pkg::*;
#(
    parameter int W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY,
    parameter int IDX_W = HASH_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [7:0]       din,
    output logic [IDX_W-1:0] idx_nxt
);
    logic [W-1:0] crc_q;
    logic [W-1:0] crc_step;

    // Purpose: advance the CRC over eight input bits, LSB first.
    always_comb begin
        logic [W-1:0] r;
        r = crc_q;
        for (int b = 0; b < 8; b++) begin
            if (r[W-1] ^ din[b]) r = {r[W-2:0], 1'b0} ^ POLY;
            else                 r = {r[W-2:0], 1'b0};
        end
        crc_step = r;
    end

    assign idx_nxt = crc_step[W-1 -: IDX_W];

    // Purpose: hold the running CRC, restarting at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= '1;
        else if (en)         crc_q <= crc_step;
    end

    // R8: after a restart the register is back at its start value.
    p_crc_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (crc_q == '1));
endmodule

// File: rtl/addr_capture.sv
// Module: collects destination address bytes and counts them.
// Shifts bytes in so byte 0 ends up in the top byte. Stops taking bytes
// once the full address is in, until clear. Assumes clear beats en.
module addr_capture
    import addr_filt_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    localparam int AW = NBYTES * 8,
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          offer,
    input  logic [7:0]    din,
    output logic          take,
    output logic          last_hit,
    output logic [AW-1:0] addr_nxt
);
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic          room;

    assign room     = (cnt_q < CW'(NBYTES));
    assign take     = offer && !clear && room;
    assign last_hit = take && (cnt_q == CW'(NBYTES - 1));
    assign addr_nxt = {addr_q[AW-9:0], din};

    // Purpose: count accepted bytes and shift them into the address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= cnt_q + 1'b1;
            addr_q <= addr_nxt;
        end
    end

    // R9: the count never runs past a full address.
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NBYTES));
    // R9: once full, further offers leave the count untouched.
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(NBYTES) && !clear) |=> (cnt_q == CW'(NBYTES)));
endmodule

// File: rtl/accept_decide.sv
// Module: turns a complete address and its hash index into a registered
// accept/reject verdict. Priority: promiscuous, then broadcast, then
// multicast by hash, then unicast by exact match (or by hash if enabled).
// Assumes fire is high for exactly the cycle the last byte is taken.
module accept_decide
    import addr_filt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int HW = HASH_WORD_W,
    localparam int IW = $clog2(2 * HW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [AW-1:0] addr,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] station,
    input  logic [HW-1:0] hash0,
    input  logic [HW-1:0] hash1,
    input  logic          promisc,
    input  logic          bcast_reject,
    input  logic          ucast_hash,
    output logic          verdict_valid,
    output logic          verdict_accept
);
    logic [2*HW-1:0] table_w;
    logic            hash_hit;
    logic            is_bcast;
    logic            is_mcast;
    logic            exact;
    logic            accept_d;

    assign table_w  = {hash1, hash0};
    assign hash_hit = table_w[idx];
    assign is_bcast = (addr == '1);
    assign is_mcast = addr[AW-8];
    assign exact    = (addr == station);

    // Purpose: pick the verdict by mode priority.
    always_comb begin
        if (promisc)       accept_d = 1'b1;
        else if (is_bcast) accept_d = !bcast_reject;
        else if (is_mcast) accept_d = hash_hit;
        else               accept_d = exact || (ucast_hash && hash_hit);
    end

    // Purpose: register the verdict and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid <= fire;
            if (fire) verdict_accept <= accept_d;
        end
    end

    // R3: promiscuous mode at decision time forces acceptance.
    p_promisc_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && promisc) |=> (verdict_valid && verdict_accept));
    // R4: rejected broadcast stays rejected outside promiscuous mode.
    p_bcast_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_bcast && bcast_reject && !promisc) |=> !verdict_accept);
endmodule

// File: rtl/rx_addr_filter.sv
// Module: receive destination address filter (top).
// Gates incoming bytes, feeds the capture and CRC units with the same
// qualified stream and issues one verdict per frame. Assumes frame_start
// is a single-cycle pulse ahead of byte 0.
module rx_addr_filter
    import addr_filt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic [15:0] stn_upper,
    input  logic [31:0] stn_lower,
    input  logic [31:0] hash_tbl0,
    input  logic [31:0] hash_tbl1,
    input  logic        mode_promisc,
    input  logic        mode_bcast_reject,
    input  logic        mode_ucast_hash,
    output logic        verdict_valid,
    output logic        verdict_accept
);
    logic      take;
    logic      last_hit;
    mac_addr_t addr_nxt;
    hash_idx_t idx_nxt;
    mac_addr_t station;

    assign station = {stn_upper, stn_lower};

    addr_capture #(.NBYTES(ADDR_BYTES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_start),
        .offer    (byte_valid),
        .din      (byte_data),
        .take     (take),
        .last_hit (last_hit),
        .addr_nxt (addr_nxt)
    );

    addr_crc_byte #(.W(CRC_W), .POLY(CRC_POLY), .IDX_W(HASH_IDX_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .en      (take),
        .din     (byte_data),
        .idx_nxt (idx_nxt)
    );

    accept_decide #(.AW(ADDR_W), .HW(HASH_WORD_W)) u_decide (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (last_hit),
        .addr           (addr_nxt),
        .idx            (idx_nxt),
        .station        (station),
        .hash0          (hash_tbl0),
        .hash1          (hash_tbl1),
        .promisc        (mode_promisc),
        .bcast_reject   (mode_bcast_reject),
        .ucast_hash     (mode_ucast_hash),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept)
    );

    // R7: a strobe follows the cycle that took the sixth byte.
    p_valid_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(last_hit));
    // R7: the strobe lasts one cycle.
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);
    // R8: a byte offered with frame_start is never taken.
    p_no_take_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !take);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [15:0] stn_upper = 16'h0211;
    logic [31:0] stn_lower = 32'h22334455;
    logic [31:0] hash_tbl0 = '0;
    logic [31:0] hash_tbl1 = '0;
    logic        mode_promisc = 1'b0;
    logic        mode_bcast_reject = 1'b0;
    logic        mode_ucast_hash = 1'b0;
    logic        verdict_valid;
    logic        verdict_accept;

    int checks = 0;
    int failures = 0;

    localparam logic [47:0] STATION = 48'h0211_2233_4455;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .stn_upper(stn_upper), .stn_lower(stn_lower),
        .hash_tbl0(hash_tbl0), .hash_tbl1(hash_tbl1),
        .mode_promisc(mode_promisc), .mode_bcast_reject(mode_bcast_reject),
        .mode_ucast_hash(mode_ucast_hash),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference hash index: bitwise CRC over bytes 0..5, LSB first.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] r = '1;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb = r[31] ^ a[40 - 8*k + j];
                r = {r[30:0], 1'b0};
                if (fb) r = r ^ 32'h04C11DB7;
            end
        end
        return r[31:26];
    endfunction

    task automatic set_only_bit(input logic [5:0] ix);
        hash_tbl0 = '0; hash_tbl1 = '0;
        if (ix[5]) hash_tbl1[ix[4:0]] = 1'b1;
        else       hash_tbl0[ix[4:0]] = 1'b1;
    endtask

    task automatic set_all_but(input logic [5:0] ix);
        hash_tbl0 = '1; hash_tbl1 = '1;
        if (ix[5]) hash_tbl1[ix[4:0]] = 1'b0;
        else       hash_tbl0[ix[4:0]] = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1; byte_valid = 1'b0;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Sends a full address; checks the strobe is absent before, present one
    // cycle after the sixth byte, and gone the cycle after.
    task automatic run_frame(input logic [47:0] a, input int gap,
                             input logic exp, input string req);
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1;
            byte_data  = a[47 - 8*i -: 8];
            @(negedge clk);
            byte_valid = 1'b0;
            if (i < 5) begin
                chk({req, " no early strobe"}, 32'(verdict_valid), 32'd0);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk({req, " no strobe in gap"}, 32'(verdict_valid), 32'd0);
                end
            end
        end
        chk({req, " strobe"}, 32'(verdict_valid), 32'd1);
        chk({req, " decision"}, 32'(verdict_accept), 32'(exp));
        @(negedge clk);
        chk({req, " strobe one cycle"}, 32'(verdict_valid), 32'd0);
    endtask

    task automatic t_reset();
        chk("R7 reset valid", 32'(verdict_valid), 32'd0);
        chk("R7 reset accept", 32'(verdict_accept), 32'd0);
    endtask

    task automatic t_unicast();
        hash_tbl0 = '0; hash_tbl1 = '0;
        run_frame(STATION, 0, 1'b1, "R1 exact match");
        for (int b = 0; b < 6; b++) begin
            logic [47:0] a = STATION;
            a[47 - 8*b -: 8] = a[47 - 8*b -: 8] ^ 8'h80;
            run_frame(a, 0, 1'b0, "R1 one byte differs");
        end
    endtask

    task automatic t_bcast();
        hash_tbl0 = '0; hash_tbl1 = '0;
        run_frame(BCAST, 0, 1'b1, "R4 broadcast allowed");
        mode_bcast_reject = 1'b1;
        run_frame(BCAST, 0, 1'b0, "R4 broadcast rejected");
        hash_tbl0 = '1; hash_tbl1 = '1;
        run_frame(BCAST, 0, 1'b0, "R4 broadcast rejected full hash");
        mode_bcast_reject = 1'b0;
    endtask

    task automatic t_mcast();
        logic [47:0] m [3] = '{48'h0100_5E00_00FB, 48'h3333_0000_0001, 48'h0180_C200_0001};
        foreach (m[k]) begin
            logic [5:0] ix = ref_idx(m[k]);
            set_only_bit(ix);
            run_frame(m[k], 0, 1'b1, "R2 hash bit set");
            set_all_but(ix);
            run_frame(m[k], 0, 1'b0, "R2 hash bit clear");
        end
    endtask

    task automatic t_all_mcast();
        hash_tbl0 = '1; hash_tbl1 = '1;
        for (int k = 0; k < 8; k++) begin
            logic [47:0] a = {8'(8'h01 | (k << 1)), 40'(k * 40'h1357_9BDF_1)};
            run_frame(a, 0, 1'b1, "R5 all-ones hash");
        end
        hash_tbl0 = '0; hash_tbl1 = '0;
    endtask

    task automatic t_promisc();
        mode_promisc = 1'b1;
        hash_tbl0 = '0; hash_tbl1 = '0;
        run_frame(48'h0A0B_0C0D_0E0F, 0, 1'b1, "R3 foreign unicast");
        run_frame(48'h0100_5E7F_0001, 0, 1'b1, "R3 multicast no hash");
        mode_bcast_reject = 1'b1;
        run_frame(BCAST, 0, 1'b1, "R3 broadcast over reject");
        mode_bcast_reject = 1'b0;
        mode_promisc = 1'b0;
    endtask

    task automatic t_ucast_hash();
        logic [47:0] a = 48'h0AAA_BBBB_CCCC;
        logic [5:0] ix = ref_idx(a);
        set_only_bit(ix);
        run_frame(a, 0, 1'b0, "R6 mode off hash ignored");
        mode_ucast_hash = 1'b1;
        run_frame(a, 0, 1'b1, "R6 mode on hash set");
        set_all_but(ix);
        run_frame(a, 0, 1'b0, "R6 mode on hash clear");
        run_frame(STATION, 0, 1'b1, "R6 exact match still accepted");
        mode_ucast_hash = 1'b0;
        hash_tbl0 = '0; hash_tbl1 = '0;
    endtask

    task automatic t_gaps();
        logic [47:0] m = 48'h0100_5E01_0203;
        set_only_bit(ref_idx(m));
        run_frame(m, 3, 1'b1, "R10 gapped multicast");
        hash_tbl0 = '0; hash_tbl1 = '0;
        run_frame(STATION, 2, 1'b1, "R10 gapped unicast");
    endtask

    task automatic t_restart();
        pulse_start();
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1'b1; byte_data = 8'hEE;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk("R8 partial frame no strobe", 32'(verdict_valid), 32'd0);
        // byte offered together with frame_start must not be taken
        @(negedge clk); frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'h55;
        @(negedge clk); frame_start = 1'b0; byte_valid = 1'b0;
        chk("R8 no strobe at restart", 32'(verdict_valid), 32'd0);
        run_frame(STATION, 0, 1'b1, "R8 fresh frame after restart");
    endtask

    task automatic t_extra();
        run_frame(STATION, 0, 1'b1, "R9 base frame");
        for (int i = 0; i < 7; i++) begin
            byte_valid = 1'b1; byte_data = 8'(i);
            @(negedge clk);
            chk("R9 surplus bytes no strobe", 32'(verdict_valid), 32'd0);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        chk("R9 surplus bytes no strobe after", 32'(verdict_valid), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast();
        t_all_mcast();
        t_promisc();
        t_ucast_hash();
        t_gaps();
        t_restart();
        t_extra();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule